// File: doc/BRIEF.md
# Conversion Sequencer with Sample Accumulator

This block controls a multi-channel sensing converter. A control word selects the operating mode, the start source, the samples per result, the sample resolution and the output format. A channel mask chooses which inputs take part. When a start event from the chosen source arrives, the sequencer pulses a start strobe toward the converter and presents a channel index. It then waits for the converter's done strobe and adds the returned sample into a running sum. After a power-of-two number of samples on one channel it emits one result, either averaged or as the raw sum, tagged with the channel.

The sequencer either handles one channel or walks every selected channel in rising index order. It stops after one pass, or it restarts on its own and keeps converting until the enable bit is cleared. The converter is treated as a plain handshake: one start pulse, then one done pulse carrying the sample some cycles later.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, conv_start and res_valid are low, and the start-source field holds the value 3 with enable clear, so no trigger pulse on any of the three trigger inputs starts a conversion.
- R2: The start source is cfg_word[4:3]: 0 accepts evt_trig, 1 accepts tmr_reload, 2 accepts sw_start, and 3 accepts none. Pulses on the inputs not selected have no effect.
- R3: cfg_word[0] enables the block. While it is clear, no trigger is accepted and no result is produced. Clearing it mid-sequence stops all further starts and results, apart from at most one start already registered.
- R4: The mode is cfg_word[2:1] (bit 1 means scan, bit 2 means continuous). In mode 0 one trigger converts only the lowest-numbered selected channel, for the configured sample count, gives one result, and the block then goes idle.
- R5: In scan modes (1 and 3) the channels set in cfg_mask are visited in ascending index order, with unselected channels skipped. An all-zero mask produces no conversions in any mode.
- R6: In continuous modes (2 and 3), after the last result of a pass the next pass starts without a trigger, with conv_start high in the same cycle as res_valid.
- R7: In single-pass modes a trigger that arrives while a sequence is running is ignored.
- R8: cfg_word[7:5] = a gives 2^a samples per result for a = 0..6. The value 7 gives 1 sample.
- R9: cfg_word[10] clear outputs the sum shifted right by a, which is the average. Set, it outputs the full 22-bit sum.
- R10: The resolution field cfg_word[9:8] = r keeps only the low 10+2r bits of conv_sample before accumulation.
- R11: conv_start is a one-cycle pulse. The next conv_start comes in the cycle after the done pulse, never earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Loads cfg_word and cfg_mask at the clock edge |
| cfg_word | input | 11 | Control word (fields as in the requirements) |
| cfg_mask | input | 8 | Channel select mask |
| evt_trig | input | 1 | External event trigger pulse |
| tmr_reload | input | 1 | Local timer reload pulse |
| sw_start | input | 1 | Software start pulse |
| conv_start | output | 1 | Converter start strobe |
| chan_idx | output | 3 | Channel being converted |
| conv_done | input | 1 | Converter done strobe |
| conv_sample | input | 16 | Raw sample, valid with conv_done |
| res_valid | output | 1 | Result strobe |
| res_data | output | 22 | Averaged or summed result |
| res_chan | output | 3 | Channel of the result |

## Verification
Two functions share one cycle: the result strobe of a finished channel and the start strobe of the next conversion. This happens when a scan moves to its next channel and when a continuous pass wraps around. The bench runs continuous and scan configurations and counts the cycles where both strobes are high, and a behavioural model predicts both strobes on every clock. A second collision, a trigger that lands while a single-pass sequence is busy, is provoked by pulsing the software start mid-sequence; the check is judged by the number of results.

// File: rtl/conv_seq_pkg.sv
`timescale 1ns/1ps
package conv_seq_pkg;
  localparam int unsigned SMP_W   = 16;
  localparam int unsigned LOG_MAX = 6;
  localparam int unsigned SUM_W   = SMP_W + LOG_MAX;

  localparam logic [1:0] SRC_EVT  = 2'd0;
  localparam logic [1:0] SRC_TMR  = 2'd1;
  localparam logic [1:0] SRC_SW   = 2'd2;
  localparam logic [1:0] SRC_NONE = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_FIRE, ST_WAIT} seq_state_e;

  typedef struct packed {
    logic       keep_sum;
    logic [1:0] res;
    logic [2:0] acc;
    logic [1:0] src;
    logic [1:0] mode;
    logic       en;
  } seq_cfg_t;

  // exponent actually used; the reserved code folds to one sample
  function automatic logic [2:0] eff_log(input logic [2:0] acc);
    return (acc == 3'd7) ? 3'd0 : acc;
  endfunction

  // keep the low 10+2r bits of a raw sample
  function automatic logic [SMP_W-1:0] trim_sample(input logic [SMP_W-1:0] s,
                                                   input logic [1:0] r);
    logic [SMP_W-1:0] keep;
    keep = {SMP_W{1'b1}} >> (3'd6 - {r, 1'b0});
    return s & keep;
  endfunction

  function automatic logic [SUM_W-1:0] shape(input logic [SUM_W-1:0] sum,
                                             input logic [2:0] lg,
                                             input logic keep);
    return keep ? sum : (sum >> lg);
  endfunction
endpackage

// File: rtl/cs_trig_sel.sv
`timescale 1ns/1ps
module cs_trig_sel
  import conv_seq_pkg::*;
(
  input  logic [1:0] src,
  input  logic       evt,
  input  logic       tmr,
  input  logic       sw,
  output logic       hit
);
  always_comb begin
    case (src)
      SRC_EVT: hit = evt;
      SRC_TMR: hit = tmr;
      SRC_SW:  hit = sw;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/cs_chan_pick.sv
`timescale 1ns/1ps
module cs_chan_pick #(
  parameter int unsigned NCH  = 8,
  parameter int unsigned CH_W = 3
) (
  input  logic [NCH-1:0]  mask,
  input  logic [CH_W-1:0] cur,
  output logic            first_ok,
  output logic [CH_W-1:0] first_idx,
  output logic            next_ok,
  output logic [CH_W-1:0] next_idx
);
  // descending walk so the lowest qualifying index wins
  always_comb begin
    first_ok  = 1'b0;
    first_idx = '0;
    next_ok   = 1'b0;
    next_idx  = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i]) begin
        first_ok  = 1'b1;
        first_idx = CH_W'(i);
      end
      if (mask[i] && (i > int'(cur))) begin
        next_ok  = 1'b1;
        next_idx = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/cs_accum.sv
`timescale 1ns/1ps
module cs_accum
  import conv_seq_pkg::*;
#(
  parameter int unsigned CH_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic [SMP_W-1:0] sample,
  input  logic [2:0]       lg,
  input  logic             keep_sum,
  input  logic [CH_W-1:0]  chan,
  output logic             batch_end,
  output logic             res_valid,
  output logic [SUM_W-1:0] res_data,
  output logic [CH_W-1:0]  res_chan
);
  localparam int unsigned CNT_W = LOG_MAX + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] sum_q, sum_nx;

  assign sum_nx    = sum_q + SUM_W'(sample);
  assign batch_end = take && ((cnt_q + CNT_W'(1)) == (CNT_W'(1) << lg));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      sum_q     <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_chan  <= '0;
    end else begin
      res_valid <= 1'b0;
      if (clear) begin
        cnt_q <= '0;
        sum_q <= '0;
      end else if (take) begin
        if (batch_end) begin
          cnt_q     <= '0;
          sum_q     <= '0;
          res_valid <= 1'b1;
          res_data  <= shape(sum_nx, lg, keep_sum);
          res_chan  <= chan;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
          sum_q <= sum_nx;
        end
      end
    end
  end

  // R8
  result_needs_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(take));
endmodule

// File: rtl/conv_sequencer.sv
`timescale 1ns/1ps
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic [10:0]            cfg_word,
  input  logic [NCH-1:0]         cfg_mask,
  input  logic                   evt_trig,
  input  logic                   tmr_reload,
  input  logic                   sw_start,
  output logic                   conv_start,
  output logic [$clog2(NCH)-1:0] chan_idx,
  input  logic                   conv_done,
  input  logic [SMP_W-1:0]       conv_sample,
  output logic                   res_valid,
  output logic [SUM_W-1:0]       res_data,
  output logic [$clog2(NCH)-1:0] res_chan
);
  localparam int unsigned CH_W = $clog2(NCH);

  seq_cfg_t         cfg_q;
  logic [NCH-1:0]   mask_q;
  seq_state_e       state_q, state_d;
  logic [CH_W-1:0]  chan_q, chan_d;
  logic             trig_hit, first_ok, next_ok, batch_end, take, clear;
  logic [CH_W-1:0]  first_idx, next_idx;
  logic             scan_mode, cont_mode;

  assign scan_mode = cfg_q.mode[0];
  assign cont_mode = cfg_q.mode[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '{keep_sum: 1'b0, res: 2'd0, acc: 3'd0, src: SRC_NONE, mode: 2'd0, en: 1'b0};
      mask_q <= '0;
    end else if (cfg_wr) begin
      cfg_q  <= seq_cfg_t'(cfg_word);
      mask_q <= cfg_mask;
    end
  end

  cs_trig_sel u_trig (
    .src (cfg_q.src),
    .evt (evt_trig),
    .tmr (tmr_reload),
    .sw  (sw_start),
    .hit (trig_hit)
  );

  cs_chan_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
    .mask      (mask_q),
    .cur       (chan_q),
    .first_ok  (first_ok),
    .first_idx (first_idx),
    .next_ok   (next_ok),
    .next_idx  (next_idx)
  );

  assign take  = (state_q == ST_WAIT) && conv_done && cfg_q.en;
  assign clear = !cfg_q.en || (state_q == ST_IDLE);

  cs_accum #(.CH_W(CH_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .take      (take),
    .sample    (trim_sample(conv_sample, cfg_q.res)),
    .lg        (eff_log(cfg_q.acc)),
    .keep_sum  (cfg_q.keep_sum),
    .chan      (chan_q),
    .batch_end (batch_end),
    .res_valid (res_valid),
    .res_data  (res_data),
    .res_chan  (res_chan)
  );

  always_comb begin
    state_d = state_q;
    chan_d  = chan_q;
    if (!cfg_q.en) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (trig_hit && first_ok) begin
          state_d = ST_FIRE;
          chan_d  = first_idx;
        end
        ST_FIRE: state_d = ST_WAIT;
        ST_WAIT: if (conv_done) begin
          if (!batch_end) begin
            state_d = ST_FIRE;
          end else if (scan_mode && next_ok) begin
            state_d = ST_FIRE;
            chan_d  = next_idx;
          end else if (cont_mode && first_ok) begin
            state_d = ST_FIRE;
            chan_d  = first_idx;
          end else begin
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      chan_q  <= '0;
    end else begin
      state_q <= state_d;
      chan_q  <= chan_d;
    end
  end

  assign conv_start = (state_q == ST_FIRE);
  assign chan_idx   = chan_q;

  // R11
  start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R11
  start_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !conv_done) |=> !conv_start);

  // R2
  no_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && cfg_q.src == SRC_NONE) |=> !conv_start);

  // R3
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.en |=> (!conv_start && !res_valid));

  // R6
  cont_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && cfg_q.en && $past(cfg_q.en) && $past(cont_mode) && $past(|mask_q))
      |-> conv_start);
endmodule

// File: tb/conv_sequencer_test.sv
`timescale 1ns/1ps
module conv_sequencer_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0, cfg_wr = 1'b0;
  logic [10:0] cfg_word = '0;
  logic [7:0]  cfg_mask = '0;
  logic        evt_trig = 1'b0, tmr_reload = 1'b0, sw_start = 1'b0, conv_done = 1'b0;
  logic [15:0] conv_sample = '0;
  logic        conv_start, res_valid;
  logic [2:0]  chan_idx, res_chan;
  logic [21:0] res_data;

  conv_sequencer uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word), .cfg_mask(cfg_mask),
    .evt_trig(evt_trig), .tmr_reload(tmr_reload), .sw_start(sw_start),
    .conv_start(conv_start), .chan_idx(chan_idx), .conv_done(conv_done),
    .conv_sample(conv_sample), .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan)
  );

  int n_chk = 0, n_bad = 0;
  string tag = "R1";

  // reference model state
  int m_en = 0, m_mode = 0, m_src = 3, m_acc = 0, m_res = 0, m_ns = 0, m_mask = 0;
  int phase = 0, cur = 0, cnt = 0;
  int q[$];
  longint sum = 0;
  bit e_start = 0, e_valid = 0;
  int e_idx = 0, e_chan = 0;
  longint e_data = 0;

  // converter model and observation
  int cd = -1, k = 0, last_sample_drv = 0;
  longint drv_sum = 0;
  int n_starts = 0, n_res = 0, n_double = 0, coinc = 0, last_chan = 0, last_gap = 0, since_start = 0;
  bit prev_start = 0;
  longint last_data = 0;
  int chan_log[$];

  task automatic chk(string t, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  function automatic int eff(int a);
    return (a == 7) ? 0 : a;
  endfunction

  function automatic longint keep_bits(longint s, int r);
    return s & ((longint'(1) << (10 + 2 * r)) - 1);
  endfunction

  task automatic build();
    q.delete();
    for (int i = 0; i < 8; i++)
      if (m_mask[i] && (((m_mode & 1) != 0) || q.size() == 0)) q.push_back(i);
  endtask

  task automatic adv();
    bit trig;
    trig = (m_src == 0 && evt_trig) || (m_src == 1 && tmr_reload) || (m_src == 2 && sw_start);
    e_valid = 0;
    if (m_en == 0) begin
      phase = 0; sum = 0; cnt = 0;
    end else begin
      case (phase)
        0: begin
          sum = 0; cnt = 0;
          if (trig && m_mask != 0) begin build(); cur = q[0]; phase = 1; end
        end
        1: phase = 2;
        default: if (conv_done) begin
          sum += keep_bits(conv_sample, m_res);
          cnt++;
          if (cnt == (1 << eff(m_acc))) begin
            e_valid = 1;
            e_data  = (m_ns != 0) ? sum : (sum >> eff(m_acc));
            e_chan  = cur;
            sum = 0; cnt = 0;
            void'(q.pop_front());
            if (q.size() == 0) begin
              if (m_mode >= 2) begin build(); cur = q[0]; phase = 1; end
              else phase = 0;
            end else begin
              cur = q[0]; phase = 1;
            end
          end else phase = 1;
        end
      endcase
    end
    if (cfg_wr) begin
      m_en = cfg_word[0]; m_mode = cfg_word[2:1]; m_src = cfg_word[4:3];
      m_acc = cfg_word[7:5]; m_res = cfg_word[9:8]; m_ns = cfg_word[10]; m_mask = cfg_mask;
    end
    e_start = (phase == 1);
    e_idx   = cur;
  endtask

  task automatic tick();
    chk({tag, " conv_start"}, conv_start, e_start);
    if (e_start) chk({tag, " chan_idx"}, chan_idx, e_idx);
    chk({tag, " res_valid"}, res_valid, e_valid);
    if (e_valid) begin
      chk({tag, " res_data"}, res_data, e_data);
      chk({tag, " res_chan"}, res_chan, e_chan);
    end
    if (conv_start) begin
      n_starts++;
      if (prev_start) n_double++;
      last_gap = since_start; since_start = 0;
    end else since_start++;
    if (conv_start && res_valid) coinc++;
    if (res_valid) begin
      n_res++; last_chan = res_chan; last_data = res_data; chan_log.push_back(res_chan);
    end
    prev_start = conv_start;
    conv_done = 1'b0;
    if (cd > 0) cd--;
    if (cd == 0) begin
      k++;
      conv_done = 1'b1;
      conv_sample = 16'(k * 40503 + 12345);
      last_sample_drv = conv_sample;
      drv_sum += keep_bits(conv_sample, m_res);
      cd = -1;
    end
    if (conv_start) cd = 10 + 2 * m_res;
    adv();
    @(negedge clk);
    cfg_wr = 1'b0; evt_trig = 1'b0; tmr_reload = 1'b0; sw_start = 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) tick();
  endtask

  task automatic wcfg(int en, int mode, int src, int acc, int res, int ns, int mask);
    cfg_wr   = 1'b1;
    cfg_word = {1'(ns), 2'(res), 3'(acc), 2'(src), 2'(mode), 1'(en)};
    cfg_mask = 8'(mask);
    tick();
  endtask

  task automatic clr();
    n_starts = 0; n_res = 0; coinc = 0; drv_sum = 0; chan_log.delete();
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset conv_start", conv_start, 0);
    chk("R1 reset res_valid", res_valid, 0);
    rst_n = 1'b1;
    tag = "R1";
    clr(); evt_trig = 1; tmr_reload = 1; sw_start = 1; tick(); run(30);
    chk("R1 no start after reset", n_starts, 0);

    tag = "R2";
    wcfg(1, 0, 3, 0, 0, 0, 'h04);
    clr(); evt_trig = 1; tmr_reload = 1; sw_start = 1; tick(); run(30);
    chk("R2 source 3 accepts nothing", n_starts, 0);
    wcfg(1, 0, 0, 0, 0, 0, 'h04);
    clr(); tmr_reload = 1; sw_start = 1; tick(); run(30);
    chk("R2 event source ignores others", n_starts, 0);
    clr(); evt_trig = 1; tick(); run(30);
    chk("R2 event source starts", n_starts, 1);
    chk("R2 event source result", n_res, 1);
    wcfg(1, 0, 1, 0, 0, 0, 'h04);
    clr(); evt_trig = 1; sw_start = 1; tick(); run(30);
    chk("R2 timer source ignores others", n_starts, 0);
    clr(); tmr_reload = 1; tick(); run(30);
    chk("R2 timer source starts", n_starts, 1);
    wcfg(1, 0, 2, 0, 0, 0, 'h04);
    clr(); sw_start = 1; tick(); run(30);
    chk("R2 software source starts", n_starts, 1);

    tag = "R4";
    wcfg(1, 0, 2, 2, 1, 0, 'h2C);
    clr(); sw_start = 1; tick(); run(100);
    chk("R4 four conversions", n_starts, 4);
    chk("R4 one result", n_res, 1);
    chk("R4 lowest selected channel", last_chan, 2);
    chk("R11 start spacing equals conversion length", last_gap, 12);

    tag = "R7";
    clr(); sw_start = 1; tick(); run(5); sw_start = 1; tick(); run(20); sw_start = 1; tick(); run(100);
    chk("R7 busy triggers ignored (results)", n_res, 1);
    chk("R7 busy triggers ignored (starts)", n_starts, 4);

    tag = "R5";
    wcfg(1, 1, 2, 1, 0, 0, 'hA5);
    clr(); sw_start = 1; tick(); run(200);
    chk("R5 one result per selected channel", n_res, 4);
    if (chan_log.size() == 4) begin
      chk("R5 order 0", chan_log[0], 0);
      chk("R5 order 1", chan_log[1], 2);
      chk("R5 order 2", chan_log[2], 5);
      chk("R5 order 3", chan_log[3], 7);
    end
    wcfg(1, 1, 2, 0, 0, 0, 0);
    clr(); sw_start = 1; tick(); run(30);
    chk("R5 empty mask no start", n_starts, 0);

    tag = "R6";
    wcfg(1, 3, 0, 0, 0, 0, 'h18);
    clr(); evt_trig = 1; tick(); run(120);
    chk("R6 keeps running without trigger", n_res >= 8, 1);
    chk("R6 restart coincides with result", coinc, n_res);
    if (chan_log.size() >= 3) begin
      chk("R6 pass order a", chan_log[0], 3);
      chk("R6 pass order b", chan_log[1], 4);
      chk("R6 wraps to first", chan_log[2], 3);
    end

    tag = "R3";
    wcfg(0, 3, 0, 0, 0, 0, 'h18);
    tick();
    clr(); evt_trig = 1; tick(); run(50);
    chk("R3 disabled: no start", n_starts, 0);
    chk("R3 disabled: no result", n_res, 0);

    tag = "R6";
    wcfg(1, 2, 1, 1, 0, 0, 'h40);
    clr(); tmr_reload = 1; tick(); run(100);
    chk("R6 continuous single repeats", n_res >= 3, 1);
    begin
      int wrong = 0;
      foreach (chan_log[i]) if (chan_log[i] != 6) wrong++;
      chk("R6 continuous single stays on channel", wrong, 0);
    end
    tag = "R3";
    wcfg(0, 2, 1, 1, 0, 0, 'h40);
    run(30);

    tag = "R8";
    wcfg(1, 0, 2, 7, 0, 0, 'h01);
    clr(); sw_start = 1; tick(); run(40);
    chk("R8 reserved code one sample", n_starts, 1);
    chk("R8 reserved code one result", n_res, 1);
    wcfg(1, 0, 2, 6, 0, 0, 'h01);
    clr(); sw_start = 1; tick(); run(720);
    chk("R8 sixty-four samples", n_starts, 64);
    chk("R8 one result for 64", n_res, 1);

    tag = "R9";
    wcfg(1, 0, 2, 3, 3, 1, 'h80);
    clr(); sw_start = 1; tick(); run(160);
    chk("R9 full sum", last_data, drv_sum);
    wcfg(1, 0, 2, 3, 3, 0, 'h80);
    clr(); sw_start = 1; tick(); run(160);
    chk("R9 averaged sum", last_data, drv_sum >> 3);

    tag = "R10";
    wcfg(1, 0, 2, 0, 0, 1, 'h01);
    clr(); sw_start = 1; tick(); run(30);
    chk("R10 ten-bit sample", last_data, last_sample_drv & 'h3FF);
    wcfg(1, 0, 2, 0, 2, 1, 'h01);
    clr(); sw_start = 1; tick(); run(30);
    chk("R10 fourteen-bit sample", last_data, last_sample_drv & 'h3FFF);

    chk("R11 no back-to-back start", n_double, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule